// File: doc/BRIEF.md
# Memory Operand Offset and Segment Generator

This block forms the offset of a memory operand from an already decoded address form: an optional base register, an optional index register, an optional displacement, and a flag that picks 16-bit or 32-bit address arithmetic. It also chooses which segment register the access goes through. That choice follows the default rule for the base register, any override the instruction carries, and the fixed segment of a string destination. For real-mode use it also forms a 20-bit physical address from a 16-bit segment value and the low 16 bits of the offset.

The register values are supplied by the caller, because register-file reading and instruction decode sit outside this block. The arithmetic is combinational. One request is accepted per cycle when `valid_i` is high, and the results appear on registered outputs one clock later. A request whose register choice is not allowed for the selected width raises `illegal_o` and leaves the address outputs as they were.

Top module: `ea_gen`

## Requirements
- R1: Register identifiers are coded 0..7 as AX, CX, DX, BX, SP, BP, SI, DI. In 16-bit mode an enabled base must be BX (3) or BP (5), and an enabled index must be SI (6) or DI (7).
- R2: In 16-bit mode the offset is base + index + displacement modulo 2^16, and `ea_o[31:16]` is zero. The scale input is ignored, and a full displacement takes only `disp_i[15:0]`.
- R3: In 32-bit mode any register may be the base. The index value is multiplied by 2^`scale_i` (1, 2, 4 or 8), and the sum wraps modulo 2^32.
- R4: `disp_sel_i` is coded as 0 for no displacement, 1 for `disp_i[7:0]` sign-extended to the address width, and 2 or 3 for a full-width displacement.
- R5: Segment codes are ES=0, CS=1, SS=2, DS=3. With no override and no string destination, the segment is SS when the enabled base is BP (id 5) and DS otherwise.
- R6: When `ovr_en_i` is set, `ovr_seg_i` replaces the default segment.
- R7: When `str_dst_i` is set, the segment is ES, even if an override is present.
- R8: `phys_o` equals `seg_val_i`·16 + `ea_o[15:0]` modulo 2^20.
- R9: An index of SP in 32-bit mode, or a 16-bit base or index outside the set allowed in R1, sets `illegal_o` to 1. In that case `ea_o`, `seg_o` and `phys_o` keep their previous values. A legal request clears `illegal_o`.
- R10: Outputs update on the rising clock edge at which `valid_i` is high. While `valid_i` is low, all outputs, including `illegal_o`, hold.
- R11: After reset `ea_o`=0, `seg_o`=DS, `phys_o`=0 and `illegal_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| mode32_i | input | 1 | 1 selects 32-bit address arithmetic, 0 selects 16-bit |
| base_en_i | input | 1 | Base register used |
| base_id_i | input | 3 | Base register identifier |
| base_val_i | input | 32 | Base register value |
| idx_en_i | input | 1 | Index register used |
| idx_id_i | input | 3 | Index register identifier |
| idx_val_i | input | 32 | Index register value |
| scale_i | input | 2 | Index shift amount (32-bit mode) |
| disp_sel_i | input | 2 | Displacement form |
| disp_i | input | 32 | Displacement value |
| ovr_en_i | input | 1 | Segment override present |
| ovr_seg_i | input | 2 | Override segment code |
| str_dst_i | input | 1 | Operand is a string destination |
| seg_val_i | input | 16 | Segment value for real-mode address |
| ea_o | output | 32 | Registered offset |
| seg_o | output | 2 | Registered segment code |
| phys_o | output | 20 | Registered real-mode physical address |
| illegal_o | output | 1 | Last request used a disallowed register |

## Verification
The bench builds the block with its default parameters: a 32-bit address width, a 16-bit legacy offset and segment value, and a 4-bit segment shift. With these values, wrap at both 2^16 and 2^32 can be reached with small operands, and so can the carry out of the 20-bit physical sum. The vectors place an illegal request directly after a legal one, so that the held address can be seen at the ports. They also cover segment choice under every combination of BP base, override and string destination.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    R_AX = 3'd0, R_CX = 3'd1, R_DX = 3'd2, R_BX = 3'd3,
    R_SP = 3'd4, R_BP = 3'd5, R_SI = 3'd6, R_DI = 3'd7
  } reg_id_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0, SEG_CS = 2'd1, SEG_SS = 2'd2, SEG_DS = 2'd3
  } seg_e;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0, DISP_BYTE = 2'd1, DISP_FULL = 2'd2, DISP_FULL2 = 2'd3
  } disp_e;
endpackage

// File: rtl/ea_legal_chk.sv
module ea_legal_chk
  import ea_pkg::*;
(
  input  logic       mode32_i,
  input  logic       base_en_i,
  input  logic [2:0] base_id_i,
  input  logic       idx_en_i,
  input  logic [2:0] idx_id_i,
  output logic       illegal_o
);
  logic bad16_base, bad16_idx, bad32_idx;

  always_comb begin
    bad16_base = base_en_i && !(base_id_i == R_BX || base_id_i == R_BP);
    bad16_idx  = idx_en_i  && !(idx_id_i  == R_SI || idx_id_i  == R_DI);
    bad32_idx  = idx_en_i  && (idx_id_i == R_SP);
    illegal_o  = mode32_i ? bad32_idx : (bad16_base || bad16_idx);
  end
endmodule

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic          mode32_i,
  input  logic          base_en_i,
  input  logic [AW-1:0] base_val_i,
  input  logic          idx_en_i,
  input  logic [AW-1:0] idx_val_i,
  input  logic [1:0]    scale_i,
  input  logic [1:0]    disp_sel_i,
  input  logic [AW-1:0] disp_i,
  output logic [AW-1:0] sum_o
);
  localparam logic [AW-1:0] LO_MASK = {{(AW-OW){1'b0}}, {OW{1'b1}}};

  logic [AW-1:0] b_term, i_term, d_term, raw;

  always_comb begin
    b_term = base_en_i ? base_val_i : '0;
    i_term = idx_en_i ? (mode32_i ? (idx_val_i << scale_i) : idx_val_i) : '0;
    case (disp_e'(disp_sel_i))
      DISP_NONE: d_term = '0;
      DISP_BYTE: d_term = {{(AW-8){disp_i[7]}}, disp_i[7:0]};
      default:   d_term = mode32_i ? disp_i : (disp_i & LO_MASK);
    endcase
    if (!mode32_i) begin
      b_term = b_term & LO_MASK;
      i_term = i_term & LO_MASK;
    end
    raw   = b_term + i_term + d_term;
    sum_o = mode32_i ? raw : (raw & LO_MASK);
  end
endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
  import ea_pkg::*;
(
  input  logic       base_en_i,
  input  logic [2:0] base_id_i,
  input  logic       ovr_en_i,
  input  logic [1:0] ovr_seg_i,
  input  logic       str_dst_i,
  output logic [1:0] seg_o
);
  always_comb begin
    if (str_dst_i)                              seg_o = SEG_ES;
    else if (ovr_en_i)                          seg_o = ovr_seg_i;
    else if (base_en_i && base_id_i == R_BP)    seg_o = SEG_SS;
    else                                        seg_o = SEG_DS;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OW    = 16,
  parameter int SEGW  = 16,
  parameter int SHIFT = 4,
  localparam int PAW  = SEGW + SHIFT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            mode32_i,
  input  logic            base_en_i,
  input  logic [2:0]      base_id_i,
  input  logic [AW-1:0]   base_val_i,
  input  logic            idx_en_i,
  input  logic [2:0]      idx_id_i,
  input  logic [AW-1:0]   idx_val_i,
  input  logic [1:0]      scale_i,
  input  logic [1:0]      disp_sel_i,
  input  logic [AW-1:0]   disp_i,
  input  logic            ovr_en_i,
  input  logic [1:0]      ovr_seg_i,
  input  logic            str_dst_i,
  input  logic [SEGW-1:0] seg_val_i,
  output logic [AW-1:0]   ea_o,
  output logic [1:0]      seg_o,
  output logic [PAW-1:0]  phys_o,
  output logic            illegal_o
);
  logic           bad_c;
  logic [AW-1:0]  sum_c;
  logic [1:0]     seg_c;
  logic [PAW-1:0] phys_c;

  ea_legal_chk u_legal (
    .mode32_i  (mode32_i),
    .base_en_i (base_en_i),
    .base_id_i (base_id_i),
    .idx_en_i  (idx_en_i),
    .idx_id_i  (idx_id_i),
    .illegal_o (bad_c)
  );

  ea_offset_sum #(.AW(AW), .OW(OW)) u_sum (
    .mode32_i   (mode32_i),
    .base_en_i  (base_en_i),
    .base_val_i (base_val_i),
    .idx_en_i   (idx_en_i),
    .idx_val_i  (idx_val_i),
    .scale_i    (scale_i),
    .disp_sel_i (disp_sel_i),
    .disp_i     (disp_i),
    .sum_o      (sum_c)
  );

  ea_seg_pick u_seg (
    .base_en_i (base_en_i),
    .base_id_i (base_id_i),
    .ovr_en_i  (ovr_en_i),
    .ovr_seg_i (ovr_seg_i),
    .str_dst_i (str_dst_i),
    .seg_o     (seg_c)
  );

  // real-mode address: segment shifted plus low offset, carry dropped
  always_comb begin
    phys_c = {seg_val_i, {SHIFT{1'b0}}} + {{(PAW-OW){1'b0}}, sum_c[OW-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o      <= '0;
      seg_o     <= SEG_DS;
      phys_o    <= '0;
      illegal_o <= 1'b0;
    end else if (valid_i) begin
      illegal_o <= bad_c;
      if (!bad_c) begin
        ea_o   <= sum_c;
        seg_o  <= seg_c;
        phys_o <= phys_c;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OW    = 16,
  parameter int SEGW  = 16,
  parameter int SHIFT = 4,
  localparam int PAW  = SEGW + SHIFT
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            mode32_i,
  input logic            base_en_i,
  input logic [2:0]      base_id_i,
  input logic [AW-1:0]   base_val_i,
  input logic            idx_en_i,
  input logic [2:0]      idx_id_i,
  input logic [AW-1:0]   idx_val_i,
  input logic [1:0]      scale_i,
  input logic [1:0]      disp_sel_i,
  input logic [AW-1:0]   disp_i,
  input logic            ovr_en_i,
  input logic [1:0]      ovr_seg_i,
  input logic            str_dst_i,
  input logic [SEGW-1:0] seg_val_i,
  input logic [AW-1:0]   ea_o,
  input logic [1:0]      seg_o,
  input logic [PAW-1:0]  phys_o,
  input logic            illegal_o
);
  // R9
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) && illegal_o |-> ea_o == $past(ea_o) && seg_o == $past(seg_o));

  // R2
  narrow_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) && !$past(mode32_i) && !illegal_o |-> ea_o[AW-1:OW] == '0);

  // R7
  str_dst_es_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) && $past(str_dst_i) && !illegal_o |-> seg_o == SEG_ES);

  // R6
  override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) && $past(ovr_en_i) && !$past(str_dst_i) && !illegal_o
      |-> seg_o == $past(ovr_seg_i));

  // R8
  phys_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) && !illegal_o
      |-> phys_o == PAW'({$past(seg_val_i), {SHIFT{1'b0}}} + {{(PAW-OW){1'b0}}, ea_o[OW-1:0]}));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(ea_o) && $stable(phys_o) && $stable(illegal_o));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .OW(OW), .SEGW(SEGW), .SHIFT(SHIFT)) u_chk (.*);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        m32;
    logic        ben;
    logic [2:0]  bid;
    logic [31:0] bval;
    logic        ien;
    logic [2:0]  iid;
    logic [31:0] ival;
    logic [1:0]  sc;
    logic [1:0]  dsel;
    logic [31:0] disp;
    logic        oen;
    logic [1:0]  oseg;
    logic        sdst;
    logic [15:0] segv;
    logic [31:0] eea;
    logic [1:0]  eseg;
    logic        eill;
    logic [19:0] ephys;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R1 R2 R4 R5 R8: BX+SI-128, DS
    '{1'b0,1'b1,3'd3,32'h1234,1'b1,3'd6,32'h0100,2'd0,2'd1,32'h80,1'b0,2'd0,1'b0,16'h2000,32'h12B4,2'd3,1'b0,20'h212B4},
    // R2 R5 R8: BP+DI+0x1000 wraps at 2^16, SS, phys carry dropped
    '{1'b0,1'b1,3'd5,32'hF000,1'b1,3'd7,32'h2000,2'd0,2'd2,32'h1000,1'b0,2'd0,1'b0,16'hFFFF,32'h2000,2'd2,1'b0,20'h01FF0},
    // R2 R6: direct, upper displacement ignored, CS override
    '{1'b0,1'b0,3'd3,32'h0,1'b0,3'd6,32'h0,2'd0,2'd2,32'hABCD1234,1'b1,2'd1,1'b0,16'h1000,32'h1234,2'd1,1'b0,20'h11234},
    // R7: string destination beats override
    '{1'b0,1'b0,3'd3,32'h0,1'b1,3'd7,32'h0010,2'd0,2'd0,32'h0,1'b1,2'd1,1'b1,16'hB800,32'h0010,2'd0,1'b0,20'hB8010},
    // R3 R4: EAX + ECX*8 + disp32
    '{1'b1,1'b1,3'd0,32'h10000000,1'b1,3'd1,32'h100,2'd3,2'd2,32'h1000,1'b0,2'd0,1'b0,16'h0000,32'h10001800,2'd3,1'b0,20'h01800},
    // R3 R5: EBP + 0x20 wraps at 2^32, SS
    '{1'b1,1'b1,3'd5,32'hFFFFFFF0,1'b0,3'd6,32'h0,2'd0,2'd1,32'h20,1'b0,2'd0,1'b0,16'h0001,32'h10,2'd2,1'b0,20'h00020},
    // R3 R4 R5: ESP base + EDI*4 - 1, DS
    '{1'b1,1'b1,3'd4,32'h8000,1'b1,3'd7,32'h4,2'd2,2'd1,32'hFF,1'b0,2'd0,1'b0,16'h0000,32'h800F,2'd3,1'b0,20'h0800F},
    // R9: ESP as 32-bit index, outputs hold
    '{1'b1,1'b1,3'd0,32'h1,1'b1,3'd4,32'h2,2'd0,2'd0,32'h0,1'b0,2'd0,1'b0,16'h5000,32'h800F,2'd3,1'b1,20'h0800F},
    // R1 R9: AX as 16-bit base
    '{1'b0,1'b1,3'd0,32'h1,1'b0,3'd6,32'h0,2'd0,2'd0,32'h0,1'b1,2'd0,1'b0,16'h5000,32'h800F,2'd3,1'b1,20'h0800F},
    // R1 R9: BX as 16-bit index
    '{1'b0,1'b0,3'd3,32'h0,1'b1,3'd3,32'h5,2'd0,2'd0,32'h0,1'b0,2'd0,1'b0,16'h5000,32'h800F,2'd3,1'b1,20'h0800F},
    // R2 R9: 16-bit scale ignored, legal clears flag
    '{1'b0,1'b0,3'd3,32'h0,1'b1,3'd6,32'h0002,2'd3,2'd0,32'h0,1'b0,2'd0,1'b0,16'h0000,32'h0002,2'd3,1'b0,20'h00002}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode32_i = 1'b0;
  logic        base_en_i = 1'b0;
  logic [2:0]  base_id_i = '0;
  logic [31:0] base_val_i = '0;
  logic        idx_en_i = 1'b0;
  logic [2:0]  idx_id_i = '0;
  logic [31:0] idx_val_i = '0;
  logic [1:0]  scale_i = '0;
  logic [1:0]  disp_sel_i = '0;
  logic [31:0] disp_i = '0;
  logic        ovr_en_i = 1'b0;
  logic [1:0]  ovr_seg_i = '0;
  logic        str_dst_i = 1'b0;
  logic [15:0] seg_val_i = '0;
  logic [31:0] ea_o;
  logic [1:0]  seg_o;
  logic [19:0] phys_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ea_gen dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    mode32_i = v.m32;  base_en_i = v.ben; base_id_i = v.bid; base_val_i = v.bval;
    idx_en_i = v.ien;  idx_id_i = v.iid;  idx_val_i = v.ival; scale_i = v.sc;
    disp_sel_i = v.dsel; disp_i = v.disp; ovr_en_i = v.oen; ovr_seg_i = v.oseg;
    str_dst_i = v.sdst; seg_val_i = v.segv; valid_i = vld;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 ea", 64'(ea_o), 64'h0);
    chk("R11 seg", 64'(seg_o), 64'd3);
    chk("R11 phys", 64'(phys_o), 64'h0);
    chk("R11 illegal", 64'(illegal_o), 64'h0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      drive(VECS[k], 1'b1);
      @(posedge clk_i);
      #1;
      valid_i = 1'b0;
      chk($sformatf("vector %0d ea", k), 64'(ea_o), 64'(VECS[k].eea));
      chk($sformatf("vector %0d seg", k), 64'(seg_o), 64'(VECS[k].eseg));
      chk($sformatf("vector %0d phys", k), 64'(phys_o), 64'(VECS[k].ephys));
      chk($sformatf("vector %0d illegal", k), 64'(illegal_o), 64'(VECS[k].eill));
    end

    // R10: a new request with valid low changes nothing
    @(negedge clk_i);
    drive(VECS[0], 1'b0);
    repeat (2) @(posedge clk_i);
    #1;
    chk("R10 hold ea", 64'(ea_o), 64'h2);
    chk("R10 hold phys", 64'(phys_o), 64'h2);

    // R10: illegal flag held while idle
    @(negedge clk_i);
    drive(VECS[7], 1'b1);
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
    chk("R9 flag set", 64'(illegal_o), 64'h1);
    repeat (2) @(posedge clk_i);
    #1;
    chk("R10 flag held", 64'(illegal_o), 64'h1);

    // R5: BP as 32-bit index with another base gives DS, not SS
    @(negedge clk_i);
    drive('{1'b1,1'b1,3'd3,32'h100,1'b1,3'd5,32'h1,2'd1,2'd0,32'h0,1'b0,2'd0,1'b0,16'h0,
            32'h0,2'd0,1'b0,20'h0}, 1'b1);
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
    chk("R5 index bp ds", 64'(seg_o), 64'd3);
    chk("R3 scale x2", 64'(ea_o), 64'h102);

    // R11: reset in mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R11 async ea", 64'(ea_o), 64'h0);
    chk("R11 async seg", 64'(seg_o), 64'd3);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule